// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the management end of a two-wire serial control link. It runs on the management clock (`mdc`) and talks over a data line that is split here into an input, an output and an output enable. The block recognises read and write frames that are addressed to it. It then serves a small map of 16-bit registers, each selected by a 5-bit register index.

Several registers do more than store a value. A link bit records any loss of link and holds it until that bit is read. A fault bit holds any fault pulse until it is read. An event word keeps incoming event pulses until any write to it clears them. The low bit of the slave address and the power-up contents of the control and advertisement registers come from strap inputs, which are sampled while reset is held.

The reset is synchronous, so `mdc` must toggle while `rst_n` is low. A frame on the line has this layout:

- 32 or more ones as a preamble
- start bits `01`
- opcode `10` for a read, or `01` for a write
- a 5-bit slave address, MSB first
- a 5-bit register index, MSB first
- two turnaround bits
- 16 data bits, MSB first

Top module: `mgmt_reg_slave`

## Requirements
- R1: The slave accepts a frame only after at least PRE_LEN (32) consecutive ones sampled on `mdio_i`. The ones are followed by start `01`, a 2-bit opcode (`10` read, `01` write), a 5-bit slave address, a 5-bit register index, two turnaround bits and 16 data bits. All fields are MSB first and sampled on rising `mdc`.
- R2: On an accepted read, `mdio_oe` stays low during the first turnaround bit. It goes high with `mdio_o`=0 for the second turnaround bit. It then presents data bits 15 down to 0, one per `mdc` cycle, and drops after bit 0. In total `mdio_oe` is high for exactly 17 cycles.
- R3: The slave address is {ADDR_HI, strap_addr0}, where strap_addr0 is sampled during reset. A frame with any other address causes no drive, no register change and no read side effect.
- R4: A write takes effect on the rising edge that samples data bit 0. The writable parts are:
  - index 0, all 16 bits
  - index 4, bits 15:5
  - index 16, all 16 bits

  A write to any other index changes nothing, and `mdio_oe` stays low for the whole of a write frame.
- R5: Reset values are:
  - index 0: bit 13 = strap_mode[0], bit 12 = strap_mode[2], bit 8 = strap_mode[1], all other bits 0
  - index 4: bits 8:5 = 4'hF if strap_mode[2] is set, else 4'h1; bits 4:0 = 00001 at all times; other bits 0
  - index 2: 0007h
  - index 3: ID_LO (C0F1h)
  - index 16: 0

  Index 1 reads 7801h with bit 2 and bit 4 added. Unmapped indices read 0.
- R6: Index 1 bit 2 is a latch-low copy of `link_up`. It is loaded from `link_up` at reset and becomes 0 on any cycle where `link_up` is low. A read of index 1 returns the latched value and then reloads the bit from the current `link_up`.
- R7: Index 1 bit 4 is a latch-high record of `fault_evt`. It is 0 after reset and becomes 1 on any cycle where `fault_evt` is high. A read of index 1 returns the latched value and then reloads the bit from the current `fault_evt`.
- R8: Index 5 bits 7:0 collect `evt_i` pulses, with one sticky bit per input and bits 15:8 reading 0. A read leaves them unchanged. A write to index 5, whatever the data, clears them.
- R9: A frame with a wrong second start bit, an opcode of `00` or `11`, or a preamble shorter than PRE_LEN is ignored. Such a frame causes no drive and no register change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all logic runs on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while low |
| strap_addr0 | input | 1 | Strap for the slave address LSB |
| strap_mode | input | 3 | Strap selecting the control and advertisement defaults |
| link_up | input | 1 | Live link condition feeding the latch-low bit |
| fault_evt | input | 1 | Fault pulse feeding the latch-high bit |
| evt_i | input | EVT_W | Event pulses collected in index 5 |
| mdio_i | input | 1 | Serial data from the line |
| mdio_o | output | 1 | Serial data toward the line |
| mdio_oe | output | 1 | Drive enable for `mdio_o` |

## Verification
The bench drops the link for a single cycle between frames and then reads index 1 twice in a row. A design that did not latch the fall, or that never refreshed the bit after the read, returns the same value both times. It also sends frames with a foreign address, a bad opcode, a bad start bit and a 20-bit preamble. A slave that decoded those frames loosely would drive the line or change a register, and a later read would show the change. Writes of all-ones to read-only and unmapped indices, and an all-zero write to the event word, show whether write masking and clear-on-any-write are done right. A second reset with different straps shows whether the defaults really follow the pins.

// File: rtl/mgmt_reg_slave.sv
module mgmt_reg_slave #(
  parameter logic [3:0]  ADDR_HI = 4'b0000,
  parameter logic [15:0] ID_LO   = 16'hC0F1,
  parameter int          EVT_W   = 8,
  parameter int          PRE_LEN = 32
) (
  input  logic             mdc,
  input  logic             rst_n,
  input  logic             strap_addr0,
  input  logic [2:0]       strap_mode,
  input  logic             link_up,
  input  logic             fault_evt,
  input  logic [EVT_W-1:0] evt_i,
  input  logic             mdio_i,
  output logic             mdio_o,
  output logic             mdio_oe
);
  localparam int CW = $clog2(PRE_LEN + 1);

  typedef enum logic [1:0] {S_PRE, S_HDR, S_TA, S_DATA} st_t;

  st_t             st;
  logic [CW-1:0]   pre_cnt;
  logic [3:0]      cnt;
  logic [11:0]     hdr;
  logic [15:0]     sh;
  logic            is_rd;
  logic [4:0]      reg_a;
  logic            phy_lsb_q;
  logic [15:0]     ctrl_q, scr_q;
  logic [10:0]     adv_q;
  logic            ll_q, lh_q;
  logic [EVT_W-1:0] flg_q;
  logic [15:0]     rd_val;

  wire [12:0] hfull    = {hdr, mdio_i};
  wire        hdr_last = (st == S_HDR) && (cnt == 4'd12);
  wire        addr_ok  = hfull[9:5] == {ADDR_HI, phy_lsb_q};
  wire        rd_go    = hdr_last && addr_ok && hfull[12] && (hfull[11:10] == 2'b10);
  wire        wr_go    = hdr_last && addr_ok && hfull[12] && (hfull[11:10] == 2'b01);
  wire        rd_stat  = rd_go && (hfull[4:0] == 5'd1);
  wire        wr_done  = (st == S_DATA) && (cnt == 4'd15) && !is_rd;
  wire [15:0] wdata    = {sh[14:0], mdio_i};

  always_comb begin
    case (hfull[4:0])
      5'd0:    rd_val = ctrl_q;
      5'd1:    rd_val = {5'b01111, 6'b0, lh_q, 1'b0, ll_q, 2'b01};
      5'd2:    rd_val = 16'h0007;
      5'd3:    rd_val = ID_LO;
      5'd4:    rd_val = {adv_q, 5'b00001};
      5'd5:    rd_val = 16'(flg_q);
      5'd16:   rd_val = scr_q;
      default: rd_val = 16'h0000;
    endcase
  end

  always_ff @(posedge mdc) begin
    if (!rst_n) begin
      st      <= S_PRE;
      pre_cnt <= '0;
      cnt     <= '0;
      hdr     <= '0;
      sh      <= '0;
      is_rd   <= 1'b0;
      reg_a   <= '0;
      mdio_o  <= 1'b0;
      mdio_oe <= 1'b0;
    end else begin
      case (st)
        S_PRE: begin
          if (mdio_i) begin
            if (pre_cnt != CW'(PRE_LEN)) pre_cnt <= pre_cnt + 1'b1;
          end else if (pre_cnt == CW'(PRE_LEN)) begin
            st      <= S_HDR;
            cnt     <= '0;
            pre_cnt <= '0;
          end else begin
            pre_cnt <= '0;
          end
        end
        S_HDR: begin
          hdr <= {hdr[10:0], mdio_i};
          cnt <= cnt + 1'b1;
          if (hdr_last) begin
            cnt <= '0;
            if (rd_go || wr_go) begin
              st    <= S_TA;
              is_rd <= rd_go;
              reg_a <= hfull[4:0];
              sh    <= rd_val;
            end else begin
              st <= S_PRE;
            end
          end
        end
        S_TA: begin
          cnt <= cnt + 1'b1;
          if (cnt == 4'd0) begin
            mdio_oe <= is_rd;
            mdio_o  <= 1'b0;
          end else begin
            st     <= S_DATA;
            cnt    <= '0;
            mdio_o <= sh[15];
            sh     <= {sh[14:0], mdio_i};
          end
        end
        default: begin
          mdio_o <= sh[15];
          sh     <= {sh[14:0], mdio_i};
          cnt    <= cnt + 1'b1;
          if (cnt == 4'd15) begin
            st      <= S_PRE;
            mdio_oe <= 1'b0;
            mdio_o  <= 1'b0;
            pre_cnt <= '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge mdc) begin
    if (!rst_n) begin
      phy_lsb_q <= strap_addr0;
      ctrl_q    <= {2'b00, strap_mode[0], strap_mode[2], 3'b000, strap_mode[1], 8'h00};
      adv_q     <= {7'b0, strap_mode[2] ? 4'hF : 4'h1};
      scr_q     <= '0;
      ll_q      <= link_up;
      lh_q      <= 1'b0;
      flg_q     <= '0;
    end else begin
      ll_q  <= rd_stat ? link_up   : (ll_q & link_up);
      lh_q  <= rd_stat ? fault_evt : (lh_q | fault_evt);
      flg_q <= (wr_done && reg_a == 5'd5) ? evt_i : (flg_q | evt_i);
      if (wr_done) begin
        case (reg_a)
          5'd0:    ctrl_q <= wdata;
          5'd4:    adv_q  <= wdata[15:5];
          5'd16:   scr_q  <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/mgmt_reg_slave_chk.sv
module mgmt_reg_slave_chk (
  input logic mdc,
  input logic rst_n,
  input logic mdio_oe,
  input logic mdio_o,
  input logic link_up,
  input logic fault_evt,
  input logic ll_q,
  input logic lh_q,
  input logic phy_lsb_q,
  input logic wr_done
);
  logic [4:0] oe_run;

  always_ff @(posedge mdc) begin
    if (!rst_n) oe_run <= '0;
    else        oe_run <= mdio_oe ? oe_run + 5'd1 : 5'd0;
  end

  a_r2_ta_low: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(mdio_oe) |-> !mdio_o);

  a_r2_drive_len: assert property (@(posedge mdc) disable iff (!rst_n)
    mdio_oe |-> oe_run < 5'd17);

  a_r2_release: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(mdio_oe) |-> oe_run == 5'd17);

  a_r3_strap_hold: assert property (@(posedge mdc) disable iff (!rst_n)
    $past(rst_n) |-> $stable(phy_lsb_q));

  a_r4_no_drive_on_write: assert property (@(posedge mdc) disable iff (!rst_n)
    wr_done |-> !mdio_oe);

  a_r6_fall_needs_loss: assert property (@(posedge mdc) disable iff (!rst_n)
    $fell(ll_q) |-> !$past(link_up));

  a_r7_rise_needs_fault: assert property (@(posedge mdc) disable iff (!rst_n)
    $rose(lh_q) |-> $past(fault_evt));
endmodule

bind mgmt_reg_slave mgmt_reg_slave_chk u_chk (
  .mdc(mdc), .rst_n(rst_n), .mdio_oe(mdio_oe), .mdio_o(mdio_o),
  .link_up(link_up), .fault_evt(fault_evt), .ll_q(ll_q), .lh_q(lh_q),
  .phy_lsb_q(phy_lsb_q), .wr_done(wr_done)
);

// File: tb/sim_mgmt_reg_slave.sv
module sim_mgmt_reg_slave;
  logic       mdc = 1'b0;
  logic       rst_n = 1'b0;
  logic       strap_addr0 = 1'b1;
  logic [2:0] strap_mode = 3'b101;
  logic       link_up = 1'b1;
  logic       fault_evt = 1'b0;
  logic [7:0] evt_i = '0;
  logic       mdio_i = 1'b1;
  logic       mdio_o, mdio_oe;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  logic [15:0] m_ctrl, m_scr;
  logic [10:0] m_adv;
  logic        m_ll, m_lh;
  logic [7:0]  m_flg;
  logic [4:0]  my_addr;

  localparam logic [18:0] OE_RD = {1'b0, 1'b1, 16'hFFFF, 1'b0};

  always #4 mdc = ~mdc;

  mgmt_reg_slave u0 (
    .mdc(mdc), .rst_n(rst_n), .strap_addr0(strap_addr0), .strap_mode(strap_mode),
    .link_up(link_up), .fault_evt(fault_evt), .evt_i(evt_i),
    .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  function automatic logic [15:0] ctrl_def(input logic [2:0] m);
    return {2'b00, m[0], m[2], 3'b000, m[1], 8'h00};
  endfunction

  function automatic logic [10:0] adv_def(input logic [2:0] m);
    return {7'b0, m[2] ? 4'hF : 4'h1};
  endfunction

  function automatic logic [15:0] exp_reg(input logic [4:0] ra);
    case (ra)
      5'd0:    return m_ctrl;
      5'd1:    return 16'h7801 | (16'(m_lh) << 4) | (16'(m_ll) << 2);
      5'd2:    return 16'h0007;
      5'd3:    return 16'hC0F1;
      5'd4:    return {m_adv, 5'b00001};
      5'd5:    return {8'h00, m_flg};
      5'd16:   return m_scr;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic a0, input logic [2:0] m);
    @(negedge mdc);
    rst_n = 1'b0; strap_addr0 = a0; strap_mode = m; mdio_i = 1'b1;
    repeat (4) @(negedge mdc);
    rst_n = 1'b1;
    m_ctrl = ctrl_def(m); m_adv = adv_def(m); m_scr = '0;
    m_ll = link_up; m_lh = 1'b0; m_flg = '0; my_addr = {4'b0000, a0};
  endtask

  task automatic bit_out(input logic b);
    @(negedge mdc);
    mdio_i = b;
  endtask

  task automatic frame(input int npre, input logic [1:0] stb, input logic [1:0] op,
                       input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd,
                       output logic [15:0] rd, output logic [18:0] oev);
    for (int i = 0; i < npre; i++) bit_out(1'b1);
    bit_out(stb[1]); bit_out(stb[0]);
    bit_out(op[1]);  bit_out(op[0]);
    for (int i = 4; i >= 0; i--) bit_out(pa[i]);
    for (int i = 4; i >= 0; i--) bit_out(ra[i]);
    @(negedge mdc); oev[18] = mdio_oe; mdio_i = 1'b1;
    @(negedge mdc); oev[17] = mdio_oe; rd = '0; mdio_i = 1'b0;
    if (mdio_oe && mdio_o) oev[17] = 1'bx;
    for (int k = 15; k >= 0; k--) begin
      @(negedge mdc);
      rd[k] = mdio_o; oev[k + 1] = mdio_oe; mdio_i = wd[k];
    end
    @(negedge mdc); oev[0] = mdio_oe; mdio_i = 1'b1;
  endtask

  task automatic do_read(input string tag, input logic [4:0] ra);
    logic [15:0] rd, ex;
    logic [18:0] oev;
    ex = exp_reg(ra);
    frame(32, 2'b01, 2'b10, my_addr, ra, 16'h0000, rd, oev);
    chk({tag, " data"}, 32'(rd), 32'(ex));
    chk("R2 drive window", 32'(oev), 32'(OE_RD));
    if (ra == 5'd1) begin m_ll = link_up; m_lh = fault_evt; end
  endtask

  task automatic do_write(input string tag, input logic [4:0] ra, input logic [15:0] wd);
    logic [15:0] rd;
    logic [18:0] oev;
    frame(32, 2'b01, 2'b01, my_addr, ra, wd, rd, oev);
    chk({tag, " no drive"}, 32'(oev), 32'h0);
    case (ra)
      5'd0:  m_ctrl = wd;
      5'd4:  m_adv  = wd[15:5];
      5'd16: m_scr  = wd;
      5'd5:  m_flg  = '0;
      default: ;
    endcase
  endtask

  task automatic bad_frame(input string tag, input int npre, input logic [1:0] stb,
                           input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra,
                           input logic [15:0] wd);
    logic [15:0] rd;
    logic [18:0] oev;
    frame(npre, stb, op, pa, ra, wd, rd, oev);
    chk({tag, " ignored, no drive"}, 32'(oev), 32'h0);
  endtask

  task automatic drop_link;
    @(negedge mdc); link_up = 1'b0; m_ll = 1'b0;
    @(negedge mdc); link_up = 1'b1;
  endtask

  task automatic pulse_fault;
    @(negedge mdc); fault_evt = 1'b1; m_lh = 1'b1;
    @(negedge mdc); fault_evt = 1'b0;
  endtask

  task automatic pulse_evt(input logic [7:0] v);
    @(negedge mdc); evt_i = v; m_flg = m_flg | v;
    @(negedge mdc); evt_i = '0;
  endtask

  initial begin
    repeat (200000) @(posedge mdc);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20417));
    do_reset(1'b1, 3'b101);
    chk("R2 idle after reset", 32'(mdio_oe), 32'h0);
    do_read("R5 ctrl default", 5'd0);
    do_read("R5 adv default", 5'd4);
    do_read("R5 id2", 5'd2);
    do_read("R5 id3", 5'd3);
    do_read("R5 status", 5'd1);
    do_read("R5 scratch", 5'd16);
    do_read("R5 unmapped", 5'd9);

    do_write("R4 ctrl", 5'd0, 16'hA5A5);
    do_read("R4 ctrl back", 5'd0);
    do_write("R4 adv", 5'd4, 16'hFFFF);
    do_read("R4 adv masked", 5'd4);
    do_write("R4 ro id", 5'd2, 16'hFFFF);
    do_read("R4 id kept", 5'd2);
    do_write("R4 unmapped", 5'd9, 16'hFFFF);
    do_read("R4 unmapped zero", 5'd9);
    do_write("R1 scratch", 5'd16, 16'h8001);
    do_read("R1 scratch msb first", 5'd16);

    bad_frame("R3 foreign write", 32, 2'b01, 2'b01, 5'd0, 5'd16, 16'h1234);
    do_read("R3 scratch unchanged", 5'd16);
    drop_link();
    bad_frame("R3 foreign read", 32, 2'b01, 2'b10, 5'd3, 5'd1, 16'h0);
    bad_frame("R9 bad opcode", 32, 2'b01, 2'b11, my_addr, 5'd16, 16'h5555);
    bad_frame("R9 bad start", 32, 2'b00, 2'b01, my_addr, 5'd16, 16'h5555);
    bad_frame("R9 short preamble", 20, 2'b01, 2'b01, my_addr, 5'd16, 16'h5555);
    do_read("R9 scratch unchanged", 5'd16);

    do_read("R6 link fall latched", 5'd1);
    do_read("R6 link refreshed", 5'd1);
    pulse_fault();
    do_read("R7 fault latched", 5'd1);
    do_read("R7 fault refreshed", 5'd1);

    pulse_evt(8'h81);
    pulse_evt(8'h10);
    do_read("R8 flags set", 5'd5);
    do_read("R8 read keeps flags", 5'd5);
    do_write("R8 clear", 5'd5, 16'h0000);
    do_read("R8 flags cleared", 5'd5);

    for (int n = 0; n < 60; n++) begin
      logic [4:0]  ra;
      logic [15:0] wd;
      case ($urandom % 8)
        0: ra = 5'd0; 1: ra = 5'd1; 2: ra = 5'd2; 3: ra = 5'd3;
        4: ra = 5'd4; 5: ra = 5'd5; 6: ra = 5'd16; default: ra = 5'd9;
      endcase
      wd = 16'($urandom);
      if ($urandom % 4 == 0) drop_link();
      if ($urandom % 4 == 0) pulse_fault();
      if ($urandom % 3 == 0) pulse_evt(8'($urandom));
      case ($urandom % 4)
        0: do_read("R1 random read", ra);
        1: do_write("R4 random write", ra, wd);
        2: bad_frame("R3 random foreign", 32, 2'b01, 2'b10, my_addr ^ 5'b00010, ra, wd);
        default: bad_frame("R9 random bad op", 32, 2'b01, 2'b00, my_addr, ra, wd);
      endcase
      do_read("R1 random check", ra);
    end

    do_reset(1'b0, 3'b010);
    do_read("R5 ctrl default 2", 5'd0);
    do_read("R5 adv default 2", 5'd4);
    do_read("R5 scratch cleared", 5'd16);
    bad_frame("R3 old address", 32, 2'b01, 2'b10, 5'd1, 5'd0, 16'h0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule